// File: doc/BRIEF.md
# Command Response Buffer Controller

This block is the device side of a trusted-module command/response interface. A host reaches it through a byte-wide memory-mapped port with separate read and write strobes. The port exposes a locality request/grant pair, an identification word, a control area and a 1280-byte data buffer. Commands are written into the buffer, and the response is read back from the same buffer.

Five phases govern the buffer. In Idle the device is parked. Ready is entered when the host asks for it. Command Reception begins with the first buffer byte written. Command Execution runs from a start write until completion. Command Completion lasts until the host asks for Ready or Idle again. The request and start bits clear themselves. An idle flag tells the host when the device is parked.

Execution is done by a stub engine. It waits a parameterised number of cycles, then writes a ten-byte response header one byte per cycle, then clears start. A build option replaces every read result with 0xFF, which models an empty address slot.

Top module: `cmdbuf_ctrl`

## Requirements
- R1: Writing 1 to bit 0 of the request register (byte 0x010) outside execution moves the device to Ready on the following clock edge. The same edge clears that bit, so the bit reads 1 for exactly one cycle after the write.
- R2: The idle flag (bit 1 of the status byte 0x014) is 1 exactly while the device is in Idle. It reads 0 once Ready is reached.
- R3: From Ready, the first write into the data buffer (bytes 0x800..0xCFF) enters Reception. A start write in Ready that has no buffer write before it is refused. Buffer bytes read back what was written.
- R4: Writing 1 to bit 0 of the start register (0x018) during Reception starts execution, and start reads 1. With a latency of L cycles, start is cleared on edge E+L+10, where E is the edge of the start write.
- R5: Writing 1 to bit 1 of the request register returns the device to Idle and sets the idle flag.
- R6: Writing 1 to bit 0 of the locality control byte (0x004) sets the granted bit (bit 0 of byte 0x000) on the next edge. Nothing but reset clears it.
- R7: On completion, buffer bytes 0..9 hold the response header: tag 0x8001 in bytes 0-1, total size 10 in bytes 2-5, and a zero code in bytes 6-9. Every multi-byte field is stored most significant byte first.
- R8: The identification word at 0x008 holds the interface type 1 in bits 3:0, version 1 in bits 7:4 and the CRB-capable flag in bit 14. All its other bits read 0.
- R9: Two kinds of write are dropped: a start write outside Reception, and a buffer write during execution. Either one sets the sticky error bit (bit 0 of 0x014), and writing 1 to that bit clears it. A dropped buffer write never corrupts a header byte that the stub writes in the same cycle.
- R10: With the block built as unmapped, every read returns 0xFF. A mapped block never returns 0xFF at offset 0.
- R11: If both request bits are pending together, the Idle request wins, and both bits clear.
- R12: A synchronous active-high reset gives Idle with the idle flag set, start, error, grant and request bits clear, and reads returning 0 for these registers.
- R13: A request written during execution stays pending. It is acted on at the first edge after completion.
- R14: The six address/size words at 0x020..0x037 store any written byte, read it back and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe; data appears one cycle later |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
The stub's header writes and a host buffer write share one memory write port, so both can land on the same edge. The bench counts edges from the start write and drives a host write to header byte 2 so that it lands on exactly the edge where the stub writes that byte. It then checks that the byte holds the size field's top byte (0x00), not the host value, and that the error flag is set. A request written during execution meets completion in a similar way: the bench judges this by the status read two edges after completion.

// File: rtl/cbc_pkg.sv
`timescale 1ns/1ps
package cbc_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_READY = 3'd1,
      PH_RECV  = 3'd2,
      PH_EXEC  = 3'd3,
      PH_DONE  = 3'd4
   } cbc_phase_e;

   localparam int unsigned HDR_BYTES = 10;
   localparam int unsigned REG_SPAN  = 64;

   // word indices inside the register window
   localparam int unsigned W_LOC_STS = 0;
   localparam int unsigned W_LOC_CTL = 1;
   localparam int unsigned W_IDENT   = 2;
   localparam int unsigned W_REQ     = 4;
   localparam int unsigned W_STS     = 5;
   localparam int unsigned W_START   = 6;
   localparam int unsigned W_WIN0    = 8;
   localparam int unsigned WIN_REGS  = 6;

   function automatic logic [7:0] hdr_byte(input logic [3:0] idx,
                                           input logic [15:0] tag,
                                           input logic [31:0] size);
      logic [7:0] b;
      case (idx)
         4'd0:    b = tag[15:8];
         4'd1:    b = tag[7:0];
         4'd2:    b = size[31:24];
         4'd3:    b = size[23:16];
         4'd4:    b = size[15:8];
         4'd5:    b = size[7:0];
         default: b = 8'h00;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/cbc_phase.sv
`timescale 1ns/1ps
module cbc_phase
   import cbc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       req_rdy_set,
   input  logic       req_idle_set,
   input  logic       start_set,
   input  logic       buf_wr,
   input  logic       err_clr,
   input  logic       exec_done,
   output cbc_phase_e phase,
   output logic       req_rdy,
   output logic       req_idle,
   output logic       start,
   output logic       idle_sts,
   output logic       err,
   output logic       buf_wr_ok
);

   logic req_act;
   logic start_ok;

   assign req_act   = (phase != PH_EXEC) && (req_rdy || req_idle);
   assign start_ok  = start_set && (phase == PH_RECV) && !req_act;
   assign buf_wr_ok = buf_wr && (phase != PH_EXEC);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase    <= PH_IDLE;
         req_rdy  <= 1'b0;
         req_idle <= 1'b0;
         start    <= 1'b0;
         idle_sts <= 1'b1;
         err      <= 1'b0;
      end else begin
         if (req_act) begin
            if (req_idle) begin
               phase    <= PH_IDLE;
               idle_sts <= 1'b1;
            end else begin
               phase    <= PH_READY;
               idle_sts <= 1'b0;
            end
            req_rdy  <= 1'b0;
            req_idle <= 1'b0;
         end else if (phase == PH_READY && buf_wr) begin
            phase <= PH_RECV;
         end else if (start_ok) begin
            phase <= PH_EXEC;
            start <= 1'b1;
         end else if (phase == PH_EXEC && exec_done) begin
            phase <= PH_DONE;
            start <= 1'b0;
         end

         if (err_clr)
            err <= 1'b0;
         if ((start_set && !start_ok) || (buf_wr && phase == PH_EXEC))
            err <= 1'b1;

         if (req_rdy_set)
            req_rdy <= 1'b1;
         if (req_idle_set)
            req_idle <= 1'b1;
      end
   end

endmodule

// File: rtl/cbc_exec_stub.sv
`timescale 1ns/1ps
module cbc_exec_stub
   import cbc_pkg::*;
#(
   parameter int unsigned EXEC_CYCLES = 20,
   parameter logic [15:0] RSP_TAG     = 16'h8001,
   parameter logic [31:0] RSP_SIZE    = 32'd10
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       go,
   output logic       hdr_we,
   output logic [3:0] hdr_idx,
   output logic [7:0] hdr_data,
   output logic       done
);

   localparam int unsigned CW = $clog2(EXEC_CYCLES + HDR_BYTES + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || !go)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign hdr_we   = go && (cnt >= CW'(EXEC_CYCLES));
   assign hdr_idx  = 4'(cnt - CW'(EXEC_CYCLES));
   assign hdr_data = hdr_byte(hdr_idx, RSP_TAG, RSP_SIZE);
   assign done     = go && (cnt == CW'(EXEC_CYCLES + HDR_BYTES - 1));

endmodule

// File: rtl/cbc_databuf.sv
`timescale 1ns/1ps
module cbc_databuf #(
   parameter int unsigned DEPTH = 1280,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          sw_we,
   input  logic [AW-1:0] sw_idx,
   input  logic [7:0]    sw_data,
   input  logic          hw_we,
   input  logic [3:0]    hw_idx,
   input  logic [7:0]    hw_data,
   input  logic [AW-1:0] rd_idx,
   output logic [7:0]    rd_data
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (hw_we)
         mem[AW'(hw_idx)] <= hw_data;
      else if (sw_we)
         mem[sw_idx] <= sw_data;
   end

   assign rd_data = mem[rd_idx];

endmodule

// File: rtl/cmdbuf_ctrl.sv
`timescale 1ns/1ps
module cmdbuf_ctrl
   import cbc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned BUF_BASE    = 'h800,
   parameter int unsigned BUF_BYTES   = 1280,
   parameter int unsigned EXEC_CYCLES = 20,
   parameter logic [15:0] RSP_TAG     = 16'h8001,
   parameter logic [3:0]  IF_TYPE     = 4'h1,
   parameter logic [3:0]  IF_VER      = 4'h1,
   parameter bit          CRB_CAP     = 1'b1,
   parameter bit          MAPPED      = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);

   localparam int unsigned BUF_AW   = $clog2(BUF_BYTES);
   localparam logic [31:0] RSP_SIZE = 32'(HDR_BYTES);
   localparam logic [31:0] IDENT_W  = {16'h0, 1'b0, CRB_CAP, 6'b0, IF_VER, IF_TYPE};

   if (EXEC_CYCLES < 1) begin : g_bad_lat
      $error("EXEC_CYCLES must be at least 1");
   end
   if (BUF_BASE < REG_SPAN) begin : g_bad_base
      $error("buffer overlaps the register window");
   end
   if (BUF_BASE + BUF_BYTES >= (1 << ADDR_W)) begin : g_bad_span
      $error("buffer does not fit the address space");
   end
   if (BUF_BYTES < HDR_BYTES) begin : g_bad_size
      $error("buffer smaller than the response header");
   end

   // decode
   logic [3:0]        word;
   logic [1:0]        lane;
   logic              reg_hit;
   logic              buf_hit;
   logic [BUF_AW-1:0] buf_idx;

   assign word    = addr[5:2];
   assign lane    = addr[1:0];
   assign reg_hit = (addr < ADDR_W'(REG_SPAN));
   assign buf_hit = (addr >= ADDR_W'(BUF_BASE)) &&
                    ({1'b0, addr} < (ADDR_W+1)'(BUF_BASE + BUF_BYTES));
   assign buf_idx = BUF_AW'(addr - ADDR_W'(BUF_BASE));

   logic lane0_wr;
   logic loc_req_wr, rdy_wr, idle_wr, err_clr_wr, start_wr, buf_wr;

   assign lane0_wr   = wr_en && reg_hit && (lane == 2'd0);
   assign loc_req_wr = lane0_wr && (word == 4'(W_LOC_CTL)) && wdata[0];
   assign rdy_wr     = lane0_wr && (word == 4'(W_REQ))     && wdata[0];
   assign idle_wr    = lane0_wr && (word == 4'(W_REQ))     && wdata[1];
   assign err_clr_wr = lane0_wr && (word == 4'(W_STS))     && wdata[0];
   assign start_wr   = lane0_wr && (word == 4'(W_START))   && wdata[0];
   assign buf_wr     = wr_en && buf_hit;

   // phase machine
   cbc_phase_e phase;
   logic req_rdy, req_idle, start, idle_sts, err, buf_wr_ok, exec_done;

   cbc_phase u_phase (
      .clk          (clk),
      .rst          (rst),
      .req_rdy_set  (rdy_wr),
      .req_idle_set (idle_wr),
      .start_set    (start_wr),
      .buf_wr       (buf_wr),
      .err_clr      (err_clr_wr),
      .exec_done    (exec_done),
      .phase        (phase),
      .req_rdy      (req_rdy),
      .req_idle     (req_idle),
      .start        (start),
      .idle_sts     (idle_sts),
      .err          (err),
      .buf_wr_ok    (buf_wr_ok)
   );

   // execution stub
   logic       hdr_we;
   logic [3:0] hdr_idx;
   logic [7:0] hdr_data;

   cbc_exec_stub #(
      .EXEC_CYCLES (EXEC_CYCLES),
      .RSP_TAG     (RSP_TAG),
      .RSP_SIZE    (RSP_SIZE)
   ) u_stub (
      .clk      (clk),
      .rst      (rst),
      .go       (phase == PH_EXEC),
      .hdr_we   (hdr_we),
      .hdr_idx  (hdr_idx),
      .hdr_data (hdr_data),
      .done     (exec_done)
   );

   // shared data buffer
   logic [7:0] buf_rd;

   cbc_databuf #(
      .DEPTH (BUF_BYTES),
      .AW    (BUF_AW)
   ) u_buf (
      .clk     (clk),
      .sw_we   (buf_wr_ok),
      .sw_idx  (buf_idx),
      .sw_data (wdata),
      .hw_we   (hdr_we),
      .hw_idx  (hdr_idx),
      .hw_data (hdr_data),
      .rd_idx  (buf_idx),
      .rd_data (buf_rd)
   );

   // locality grant
   logic granted;

   always_ff @(posedge clk) begin
      if (rst)
         granted <= 1'b0;
      else if (loc_req_wr)
         granted <= 1'b1;
   end

   // address and size words
   logic [31:0] win_q [WIN_REGS];

   always_ff @(posedge clk) begin
      for (int i = 0; i < int'(WIN_REGS); i++) begin
         if (rst)
            win_q[i] <= '0;
         else if (wr_en && reg_hit && word == 4'(W_WIN0 + i))
            win_q[i][{lane, 3'b000} +: 8] <= wdata;
      end
   end

   // read path
   logic [31:0] reg_word;
   logic [2:0]  win_sel;
   logic [7:0]  rd_val;
   logic [7:0]  port_byte;

   assign win_sel = 3'(word - 4'(W_WIN0));

   always_comb begin
      reg_word = '0;
      case (word)
         4'(W_LOC_STS): reg_word[0]   = granted;
         4'(W_IDENT):   reg_word      = IDENT_W;
         4'(W_REQ):     reg_word[1:0] = {req_idle, req_rdy};
         4'(W_STS):     reg_word[1:0] = {idle_sts, err};
         4'(W_START):   reg_word[0]   = start;
         default: begin
            if (word >= 4'(W_WIN0) && word < 4'(W_WIN0 + WIN_REGS))
               reg_word = win_q[win_sel];
         end
      endcase
   end

   assign rd_val = reg_hit ? reg_word[{lane, 3'b000} +: 8] :
                   buf_hit ? buf_rd : 8'h00;

   if (MAPPED) begin : g_mapped
      assign port_byte = rd_val;
   end else begin : g_absent
      assign port_byte = 8'hFF;
   end

   always_ff @(posedge clk) begin
      if (rst)
         rdata <= 8'h00;
      else if (rd_en)
         rdata <= port_byte;
   end

endmodule

// File: rtl/cmdbuf_ctrl_chk.sv
`timescale 1ns/1ps
module cmdbuf_ctrl_chk
   import cbc_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic              wdata0,
   input cbc_phase_e        phase,
   input logic              req_rdy,
   input logic              req_idle,
   input logic              start,
   input logic              idle_sts,
   input logic              err,
   input logic              granted,
   input logic              hdr_we
);

   AST_REQ_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
      ((req_rdy || req_idle) && phase != PH_EXEC && !wr_en) |=> (!req_rdy && !req_idle)); // R1

   AST_IDLE_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
      idle_sts |-> (phase == PH_IDLE)); // R2

   AST_IDLE_PHASE_FLAG: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_IDLE) |-> idle_sts); // R5

   AST_START_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
      start |-> (phase == PH_EXEC)); // R4

   AST_EXEC_HAS_START: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EXEC) |-> start); // R4

   AST_GRANT_HOLDS: assert property (@(posedge clk) disable iff (rst)
      granted |=> granted); // R6

   AST_HDR_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
      hdr_we |-> (phase == PH_EXEC)); // R7

   AST_BAD_START_ERR: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(24) && wdata0 && phase != PH_RECV) |=> err); // R9

   AST_IDLE_REQ_WINS: assert property (@(posedge clk) disable iff (rst)
      (req_idle && phase != PH_EXEC) |=> (phase == PH_IDLE)); // R11

   AST_EXEC_HOLDS_REQ: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EXEC) |=> (phase == PH_EXEC || phase == PH_DONE)); // R13

endmodule

bind cmdbuf_ctrl cmdbuf_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata0   (wdata[0]),
   .phase    (phase),
   .req_rdy  (req_rdy),
   .req_idle (req_idle),
   .start    (start),
   .idle_sts (idle_sts),
   .err      (err),
   .granted  (granted),
   .hdr_we   (hdr_we)
);

// File: tb/test_cmdbuf_ctrl.sv
`timescale 1ns/1ps
module test_cmdbuf_ctrl;

   localparam int LAT  = 6;
   localparam int BASE = 'h800;
   localparam int SIZE = 1280;
   localparam int P_IDLE = 0, P_READY = 1, P_RECV = 2, P_EXEC = 3, P_DONE = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [7:0]  rdata_abs;

   always #2.5 clk = ~clk;

   cmdbuf_ctrl #(.EXEC_CYCLES(LAT)) i_cmdbuf_ctrl (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata)
   );

   cmdbuf_ctrl #(.EXEC_CYCLES(LAT), .MAPPED(1'b0)) i_cmdbuf_ctrl_absent (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata_abs)
   );

   int    cyc = 0;
   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R12";
   bit    finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // behavioural reference model
   int         m_phase, m_cnt;
   bit         m_idle, m_start, m_err, m_grant, m_rr, m_ri, m_rskip;
   logic [7:0] m_rdata;
   logic [7:0] m_buf [int];
   logic [7:0] m_win [int];

   function automatic logic [7:0] exp_hdr(input int k);
      case (k)
         0: return 8'h80;
         1: return 8'h01;
         5: return 8'h0A;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] reg_byte(input int a);
      case (a)
         0:  return {7'b0, m_grant};
         8:  return 8'h11;
         9:  return 8'h40;
         16: return {6'b0, m_ri, m_rr};
         20: return {6'b0, m_idle, m_err};
         24: return {7'b0, m_start};
         default: begin
            if (a >= 32 && a < 56 && m_win.exists(a)) return m_win[a];
            return 8'h00;
         end
      endcase
   endfunction

   always @(posedge clk) begin : ref_model
      int a, pre;
      bit act, bufw, startw;
      a = int'(addr);
      if (rst) begin
         m_phase = P_IDLE; m_idle = 1; m_start = 0; m_err = 0; m_grant = 0;
         m_rr = 0; m_ri = 0; m_cnt = 0; m_rdata = 8'h00; m_rskip = 0;
         m_win.delete();
      end else begin
         if (rd_en) begin
            m_rskip = 0;
            if (a < 64) m_rdata = reg_byte(a);
            else if (a >= BASE && a < BASE + SIZE) begin
               if (m_buf.exists(a - BASE)) m_rdata = m_buf[a - BASE];
               else m_rskip = 1;
            end else m_rdata = 8'h00;
         end
         pre    = m_phase;
         act    = (pre != P_EXEC) && (m_rr || m_ri);
         bufw   = wr_en && a >= BASE && a < BASE + SIZE;
         startw = wr_en && a == 24 && wdata[0];
         if (pre == P_EXEC) begin
            if (m_cnt >= LAT) m_buf[m_cnt - LAT] = exp_hdr(m_cnt - LAT);
            if (m_cnt == LAT + 9) begin m_phase = P_DONE; m_start = 0; end
            m_cnt++;
         end
         if (act) begin
            if (m_ri) begin m_phase = P_IDLE; m_idle = 1; end
            else begin m_phase = P_READY; m_idle = 0; end
            m_rr = 0; m_ri = 0;
         end else if (pre == P_READY && bufw) m_phase = P_RECV;
         else if (pre == P_RECV && startw) begin
            m_phase = P_EXEC; m_start = 1; m_cnt = 0;
         end
         if (wr_en && a == 20 && wdata[0]) m_err = 0;
         if ((startw && !(pre == P_RECV && !act)) || (bufw && pre == P_EXEC)) m_err = 1;
         if (bufw && pre != P_EXEC) m_buf[a - BASE] = wdata;
         if (wr_en && a == 16) begin
            if (wdata[0]) m_rr = 1;
            if (wdata[1]) m_ri = 1;
         end
         if (wr_en && a == 4 && wdata[0]) m_grant = 1;
         if (wr_en && a >= 32 && a < 56) m_win[a] = wdata;
      end
   end

   task automatic chk(input int got, input int exp, input string tag);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; addr = 12'(a); wdata = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] v);
      rd_en = 1'b1; addr = 12'(a);
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
      if (!m_rskip) chk(v, m_rdata, {cur_req, " model"});
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      #500000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : stimulus
      logic [7:0] v;
      int e_edge;
      bit got0;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      cur_req = "R12";
      rd(20, v); chk(v, 8'h02, "R12 status after reset");
      rd(24, v); chk(v, 8'h00, "R12 start after reset");
      rd(16, v); chk(v, 8'h00, "R12 request after reset");
      rd(0, v);  chk(v, 8'h00, "R12 grant after reset");
      cur_req = "R10";
      chk(int'(v == 8'hFF), 0, "R10 offset 0 not 0xFF");
      chk(rdata_abs, 8'hFF, "R10 unmapped read");

      cur_req = "R8";
      rd(8, v);  chk(v, 8'h11, "R8 type/version byte");
      rd(9, v);  chk(v, 8'h40, "R8 capability byte");
      rd(10, v); chk(v, 8'h00, "R8 upper byte");

      cur_req = "R14";
      rd(32, v); chk(v, 8'h00, "R14 window reset");
      wr(37, 8'h5A);
      rd(37, v); chk(v, 8'h5A, "R14 window store");
      rd(36, v); chk(v, 8'h00, "R14 neighbour lane");

      cur_req = "R6";
      wr(4, 1);
      rd(0, v); chk(v, 8'h01, "R6 granted");

      cur_req = "R9";
      wr(24, 1);
      rd(24, v); chk(v, 8'h00, "R9 start refused in idle");
      rd(20, v); chk(v, 8'h03, "R9 error set");
      wr(20, 1);
      rd(20, v); chk(v, 8'h02, "R9 error cleared");

      cur_req = "R1";
      wr(16, 1);
      rd(16, v); chk(v, 8'h01, "R1 request visible one cycle");
      rd(16, v); chk(v, 8'h00, "R1 request self-cleared");
      cur_req = "R2";
      rd(20, v); chk(v, 8'h00, "R2 idle flag cleared in ready");

      cur_req = "R3";
      wr(24, 1);
      rd(24, v); chk(v, 8'h00, "R3 start refused before reception");
      rd(20, v); chk(v, 8'h01, "R3 refusal flagged");
      wr(20, 1);
      for (int k = 0; k < 8; k++) wr(BASE + k, 8'hC0 + k);
      wr(BASE + 'h20, 8'h3C);
      rd(BASE + 3, v); chk(v, 8'hC3, "R3 buffer readback");

      cur_req = "R4";
      wr(24, 1);
      e_edge = cyc;
      rd(24, v); chk(v, 8'h01, "R4 start set");

      cur_req = "R9";
      wr(BASE + 'h20, 8'h99);
      rd(20, v); chk(v, 8'h01, "R9 write during execution flagged");
      while (cyc < e_edge + LAT + 2) @(negedge clk);
      wr(BASE + 2, 8'h77);

      cur_req = "R13";
      wr(16, 1);
      rd(16, v); chk(v, 8'h01, "R13 request pending in execution");

      cur_req = "R4";
      got0 = 1'b0;
      for (int i = 0; i < 100 && !got0; i++) begin
         rd(24, v);
         if (v == 8'h00) begin
            got0 = 1'b1;
            chk(cyc, e_edge + LAT + 11, "R4 completion edge");
         end
      end
      chk(int'(got0), 1, "R4 start cleared");

      cur_req = "R13";
      rd(20, v); chk(v, 8'h01, "R13 ready after completion");
      rd(16, v); chk(v, 8'h00, "R13 request consumed");

      cur_req = "R7";
      for (int k = 0; k < 10; k++) begin
         rd(BASE + k, v); chk(v, exp_hdr(k), "R7 header byte");
      end
      cur_req = "R9";
      rd(BASE + 'h20, v); chk(v, 8'h3C, "R9 dropped buffer write");
      rd(BASE + 2, v);    chk(v, 8'h00, "R9 header wins collision");

      cur_req = "R5";
      wr(20, 1);
      wr(16, 2);
      rd(16, v); chk(v, 8'h02, "R5 idle request visible");
      rd(20, v); chk(v, 8'h02, "R5 idle flag set");

      cur_req = "R11";
      wr(16, 1);
      idle(2);
      rd(20, v); chk(v, 8'h00, "R11 ready first");
      wr(16, 3);
      idle(1);
      rd(20, v); chk(v, 8'h02, "R11 idle request wins");
      rd(16, v); chk(v, 8'h00, "R11 both bits cleared");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule